// File: doc/BRIEF.md
# Frame Timing Site Clock Unit

This unit sits at one simulation site and turns a shared timing line into frame boundaries for that site's simulation. Two kinds of event share the line, and only the pulse width tells them apart. A short pulse is a base tic, which a central unit sends every 125 microseconds. A long pulse is a job sync tic, which comes at a much longer period set by hand, typically one to three seconds. The line is passed through a two-flop synchronizer and sampled on a prescaled enable (10 MHz by default). The width of each high pulse is measured in samples and classified when the pulse ends. A job sync pulse also counts as a base tic.

The host writes a frame length, given as a number of base tics. The unit does not start counting at once. It arms and waits for the next job sync tic, so that every site begins on the same boundary. After that it issues a frame start every N tics. Each job sync tic reloads the counter, so a frame start always coincides with the sync. If the sync arrives when the frame was not due to end, a sticky misalignment flag is set. This flag shows that the frame length does not divide the sync period. A frame length of zero is rejected.

Frame starts are also presented as a valid/ready pair. `frame_valid_o` rises with each frame start and stays high until the consumer raises `frame_ack_i`. Nothing is queued. If a new frame start arrives while the previous one is still unacknowledged, the new start takes its place and a sticky overrun flag is set. An acknowledge that falls in the same cycle as a new start retires the old start only.

Top module: `site_frame_clock`

## Requirements
- R1: After reset, all outputs are low and the unit is disarmed (neither armed nor running).
- R2: A line pulse of W samples is classified when it ends. If W < BASE_MIN (5) the pulse is ignored. If BASE_MIN <= W < SYNC_MIN (20) it is a base tic. If SYNC_MIN <= W <= SYNC_MAX (40) it is a job sync tic, which also counts as a base tic. If W > SYNC_MAX the pulse is ignored. Each job sync tic gives a one-cycle `job_sync_o` pulse.
- R3: Writing a nonzero frame count N sets `st_armed_o`. No frame start occurs until the next job sync tic. That tic produces a frame start and sets `st_run_o`.
- R4: While running, a frame start occurs on every Nth tic after the last frame start. N = 1 gives a frame start on every tic.
- R5: A job sync tic while running always produces a frame start and restarts the count of N. It sets `st_misalign_o` (sticky) unless it is the Nth tic since the last frame start.
- R6: Writing a frame count of zero sets `st_badcfg_o`, clears armed and running, and produces no frame starts, even on a job sync tic. A later nonzero write clears `st_badcfg_o`.
- R7: `frame_valid_o` rises with each frame start and holds until `frame_ack_i` is sampled high. A frame start while `frame_valid_o` is high and `frame_ack_i` is low sets `st_overrun_o` (sticky).
- R8: Any write of the frame count clears `st_misalign_o` and `st_overrun_o`.
- R9: `frame_start_o` and `job_sync_o` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| timing_line_i | input | 1 | Shared timing line, asynchronous |
| cfg_we_i | input | 1 | Write strobe for the frame count |
| cfg_count_i | input | CNT_W | Frame length in base tics |
| frame_ack_i | input | 1 | Ready for the frame-start handshake |
| frame_start_o | output | 1 | One-cycle frame start pulse |
| frame_valid_o | output | 1 | Frame start pending, held until acknowledged |
| job_sync_o | output | 1 | One-cycle job sync pulse |
| st_armed_o | output | 1 | Count loaded, waiting for job sync |
| st_run_o | output | 1 | Counting frames |
| st_misalign_o | output | 1 | Sticky: a sync fell off a frame boundary |
| st_overrun_o | output | 1 | Sticky: a frame start was lost to no acknowledge |
| st_badcfg_o | output | 1 | Last written count was zero |

## Verification
The bench first sends a burst of base tics to a unit that is armed but has not yet seen a job sync tic. A design that started counting at the write would produce frame starts during that burst. It then places sync tics both on a frame boundary and one tic short of it. A design that got this wrong would either flag a correctly aligned sync or skip the reload, and the next frame would then arrive late. The bench also sends pulses just below the base threshold and just above the sync limit, and checks the frame count afterwards. A width discriminator with open-ended ranges would count these pulses and shift every later frame start. Finally the bench covers N = 1, a zero count, and an unacknowledged pending start. A design wrong in these cases would underflow the counter, arm with a length of zero, or drop a start without setting the overrun flag.

// File: rtl/site_clk_pkg.sv
package site_clk_pkg;
  typedef enum logic [1:0] {
    RUN_OFF  = 2'd0,
    RUN_WAIT = 2'd1,
    RUN_ON   = 2'd2
  } run_state_t;

  typedef struct packed {
    logic base;
    logic sync;
  } tic_evt_t;
endpackage

// File: rtl/sc_sampler.sv
module sc_sampler #(
  parameter int SAMPLE_DIV = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic sample_en_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
    end
  end
  assign level_o = sync_q;

  generate
    if (SAMPLE_DIV <= 1) begin : g_nodiv
      assign sample_en_o = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(SAMPLE_DIV);
      localparam logic [DW-1:0] LAST = DW'(SAMPLE_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign sample_en_o = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sc_pulse_class.sv
module sc_pulse_class
  import site_clk_pkg::*;
#(
  parameter int BASE_MIN = 5,
  parameter int SYNC_MIN = 20,
  parameter int SYNC_MAX = 40
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     level_i,
  input  logic     sample_en_i,
  output tic_evt_t evt_o
);
  localparam int WW = $clog2(SYNC_MAX + 2);
  localparam logic [WW-1:0] W_BMIN = WW'(BASE_MIN);
  localparam logic [WW-1:0] W_SMIN = WW'(SYNC_MIN);
  localparam logic [WW-1:0] W_SMAX = WW'(SYNC_MAX);
  localparam logic [WW-1:0] W_SAT  = WW'(SYNC_MAX + 1);

  logic [WW-1:0] width_q;
  logic          ending, in_base, in_sync;

  assign ending  = sample_en_i && !level_i && (width_q != '0);
  assign in_base = (width_q >= W_BMIN) && (width_q <= W_SMAX);
  assign in_sync = (width_q >= W_SMIN) && (width_q <= W_SMAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= '0;
      evt_o   <= '0;
    end else begin
      evt_o.base <= ending && in_base;
      evt_o.sync <= ending && in_sync;
      if (sample_en_i) begin
        if (level_i) begin
          if (width_q != W_SAT) width_q <= width_q + 1'b1;
        end else begin
          width_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/sc_frame_ctr.sv
module sc_frame_ctr
  import site_clk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tic_evt_t         evt_i,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] cfg_count_i,
  input  logic             frame_ack_i,
  output logic             frame_start_o,
  output logic             frame_valid_o,
  output run_state_t       state_o,
  output logic             misalign_o,
  output logic             overrun_o,
  output logic             badcfg_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] len_q, cnt_q;
  logic             start_now;

  assign start_now = !cfg_we_i &&
                     (((state_o == RUN_WAIT) && evt_i.sync) ||
                      ((state_o == RUN_ON) && evt_i.base && (evt_i.sync || cnt_q == ONE)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o       <= RUN_OFF;
      len_q         <= '0;
      cnt_q         <= '0;
      frame_start_o <= 1'b0;
      frame_valid_o <= 1'b0;
      misalign_o    <= 1'b0;
      overrun_o     <= 1'b0;
      badcfg_o      <= 1'b0;
    end else begin
      frame_start_o <= start_now;
      frame_valid_o <= start_now || (frame_valid_o && !frame_ack_i);
      if (start_now && frame_valid_o && !frame_ack_i) overrun_o <= 1'b1;
      if (cfg_we_i) begin
        misalign_o <= 1'b0;
        overrun_o  <= 1'b0;
        if (cfg_count_i == '0) begin
          badcfg_o <= 1'b1;
          state_o  <= RUN_OFF;
        end else begin
          badcfg_o <= 1'b0;
          state_o  <= RUN_WAIT;
          len_q    <= cfg_count_i;
        end
      end else begin
        case (state_o)
          RUN_WAIT: if (evt_i.sync) begin
            state_o <= RUN_ON;
            cnt_q   <= len_q;
          end
          RUN_ON: if (evt_i.base) begin
            if (evt_i.sync) begin
              cnt_q <= len_q;
              if (cnt_q != ONE) misalign_o <= 1'b1;
            end else if (cnt_q == ONE) begin
              cnt_q <= len_q;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/site_frame_clock.sv
module site_frame_clock
  import site_clk_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SAMPLE_DIV = 20,
  parameter int BASE_MIN   = 5,
  parameter int SYNC_MIN   = 20,
  parameter int SYNC_MAX   = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             timing_line_i,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] cfg_count_i,
  input  logic             frame_ack_i,
  output logic             frame_start_o,
  output logic             frame_valid_o,
  output logic             job_sync_o,
  output logic             st_armed_o,
  output logic             st_run_o,
  output logic             st_misalign_o,
  output logic             st_overrun_o,
  output logic             st_badcfg_o
);
  logic       level, sample_en;
  tic_evt_t   evt;
  run_state_t state;

  sc_sampler #(.SAMPLE_DIV(SAMPLE_DIV)) u_samp (
    .clk(clk), .rst(rst), .line_i(timing_line_i),
    .level_o(level), .sample_en_o(sample_en)
  );

  sc_pulse_class #(.BASE_MIN(BASE_MIN), .SYNC_MIN(SYNC_MIN), .SYNC_MAX(SYNC_MAX)) u_cls (
    .clk(clk), .rst(rst), .level_i(level), .sample_en_i(sample_en), .evt_o(evt)
  );

  sc_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .evt_i(evt), .cfg_we_i(cfg_we_i), .cfg_count_i(cfg_count_i),
    .frame_ack_i(frame_ack_i), .frame_start_o(frame_start_o), .frame_valid_o(frame_valid_o),
    .state_o(state), .misalign_o(st_misalign_o), .overrun_o(st_overrun_o),
    .badcfg_o(st_badcfg_o)
  );

  assign job_sync_o = evt.sync;
  assign st_armed_o = (state == RUN_WAIT);
  assign st_run_o   = (state == RUN_ON);
endmodule

// File: rtl/site_frame_clock_chk.sv
module site_frame_clock_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we_i,
  input logic [CNT_W-1:0] cfg_count_i,
  input logic             frame_ack_i,
  input logic             frame_start_o,
  input logic             frame_valid_o,
  input logic             job_sync_o,
  input logic             st_armed_o,
  input logic             st_run_o,
  input logic             st_misalign_o,
  input logic             st_overrun_o,
  input logic             st_badcfg_o
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |=> !frame_start_o); // R9
  AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (rst)
    job_sync_o |=> !job_sync_o); // R9
  AST_START_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> st_run_o); // R3
  AST_SYNC_GIVES_START: assert property (@(posedge clk) disable iff (rst)
    (job_sync_o && (st_armed_o || st_run_o) && !cfg_we_i) |=> frame_start_o); // R5
  AST_BADCFG_DISARMED: assert property (@(posedge clk) disable iff (rst)
    st_badcfg_o |-> (!st_armed_o && !st_run_o)); // R6
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (frame_valid_o && !frame_ack_i) |=> frame_valid_o); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (frame_start_o && $past(frame_valid_o && !frame_ack_i)) |-> st_overrun_o); // R7
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    cfg_we_i |=> (!st_misalign_o && !st_overrun_o)); // R8
endmodule

bind site_frame_clock site_frame_clock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we_i(cfg_we_i), .cfg_count_i(cfg_count_i),
  .frame_ack_i(frame_ack_i), .frame_start_o(frame_start_o), .frame_valid_o(frame_valid_o),
  .job_sync_o(job_sync_o), .st_armed_o(st_armed_o), .st_run_o(st_run_o),
  .st_misalign_o(st_misalign_o), .st_overrun_o(st_overrun_o), .st_badcfg_o(st_badcfg_o)
);

// File: tb/site_frame_clock_test.sv
module site_frame_clock_test;
  localparam int CNT_W = 16;
  localparam int DIV   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line = 1'b0;
  logic cfg_we = 1'b0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic auto_ack = 1'b1;
  logic man_ack = 1'b0;
  logic ack;
  logic frame_start, frame_valid, job_sync;
  logic st_armed, st_run, st_mis, st_ovr, st_bad;

  int checks = 0;
  int fails = 0;
  int n_fs = 0;
  int n_js = 0;
  int long_pulse = 0;
  logic fs_prev = 1'b0;
  logic js_prev = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  assign ack = auto_ack ? frame_valid : man_ack;

  site_frame_clock #(.CNT_W(CNT_W), .SAMPLE_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .timing_line_i(line), .cfg_we_i(cfg_we), .cfg_count_i(cfg_count),
    .frame_ack_i(ack), .frame_start_o(frame_start), .frame_valid_o(frame_valid),
    .job_sync_o(job_sync), .st_armed_o(st_armed), .st_run_o(st_run),
    .st_misalign_o(st_mis), .st_overrun_o(st_ovr), .st_badcfg_o(st_bad)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (frame_start) n_fs++;
      if (job_sync) n_js++;
      if ((frame_start && fs_prev) || (job_sync && js_prev)) long_pulse++;
    end
    fs_prev = frame_start;
    js_prev = job_sync;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int len);
    @(negedge clk) line = 1'b1;
    repeat (len) @(negedge clk);
    line = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic base(input int n);
    for (int i = 0; i < n; i++) pulse(40);
  endtask

  task automatic sync_tic();
    pulse(120);
  endtask

  task automatic write_cfg(input int n);
    @(negedge clk);
    cfg_count = CNT_W'(n);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!frame_start && !frame_valid && !job_sync, "R1 frame/sync outputs", int'(frame_valid), 0);
    chk(!st_armed && !st_run, "R1 disarmed", int'(st_run), 0);
    chk(!st_mis && !st_ovr && !st_bad, "R1 flags", int'(st_bad), 0);
  endtask

  task automatic t_classify();
    int js0;
    js0 = n_js;
    base(1);
    chk(n_js == js0, "R2 base is not sync", n_js - js0, 0);
    pulse(8);
    pulse(200);
    chk(n_js == js0, "R2 glitch and long ignored", n_js - js0, 0);
    sync_tic();
    chk(n_js == js0 + 1, "R2 sync detected", n_js - js0, 1);
  endtask

  task automatic t_arm_wait();
    int f0;
    write_cfg(3);
    chk(st_armed && !st_run, "R3 armed after write", int'(st_armed), 1);
    f0 = n_fs;
    base(5);
    chk(n_fs == f0, "R3 no start before sync", n_fs - f0, 0);
    sync_tic();
    chk(n_fs == f0 + 1, "R3 start on sync", n_fs - f0, 1);
    chk(st_run && !st_armed, "R3 running", int'(st_run), 1);
  endtask

  task automatic t_period();
    int f0;
    f0 = n_fs;
    base(2);
    chk(n_fs == f0, "R4 no start before Nth tic", n_fs - f0, 0);
    base(4);
    chk(n_fs == f0 + 2, "R4 two frames in six tics", n_fs - f0, 2);
  endtask

  task automatic t_align();
    int f0;
    f0 = n_fs;
    base(2);
    sync_tic();
    chk(n_fs == f0 + 1, "R5 aligned sync starts", n_fs - f0, 1);
    chk(!st_mis, "R5 aligned sync no flag", int'(st_mis), 0);
    f0 = n_fs;
    base(1);
    sync_tic();
    chk(n_fs == f0 + 1, "R5 early sync starts", n_fs - f0, 1);
    chk(st_mis, "R5 misalign flag", int'(st_mis), 1);
    f0 = n_fs;
    base(2);
    chk(n_fs == f0, "R5 count restarted", n_fs - f0, 0);
    base(1);
    chk(n_fs == f0 + 1, "R5 frame after reload", n_fs - f0, 1);
  endtask

  task automatic t_ignored_in_run();
    int f0;
    f0 = n_fs;
    pulse(8);
    pulse(200);
    base(2);
    chk(n_fs == f0, "R2 odd widths not counted", n_fs - f0, 0);
    base(1);
    chk(n_fs == f0 + 1, "R2 count intact", n_fs - f0, 1);
  endtask

  task automatic t_overrun();
    int f0;
    auto_ack = 1'b0;
    f0 = n_fs;
    base(3);
    chk(n_fs == f0 + 1 && frame_valid, "R7 valid held", int'(frame_valid), 1);
    chk(!st_ovr, "R7 no overrun yet", int'(st_ovr), 0);
    base(3);
    chk(st_ovr, "R7 overrun set", int'(st_ovr), 1);
    chk(frame_valid, "R7 still valid", int'(frame_valid), 1);
    @(negedge clk) man_ack = 1'b1;
    @(negedge clk) man_ack = 1'b0;
    @(negedge clk);
    chk(!frame_valid, "R7 ack retires", int'(frame_valid), 0);
    auto_ack = 1'b1;
  endtask

  task automatic t_rewrite();
    write_cfg(1);
    chk(!st_mis && !st_ovr, "R8 flags cleared", int'(st_mis) + int'(st_ovr), 0);
    chk(st_armed && !st_run, "R3 rewrite rearms", int'(st_armed), 1);
  endtask

  task automatic t_one();
    int f0;
    f0 = n_fs;
    base(2);
    chk(n_fs == f0, "R3 N=1 waits for sync", n_fs - f0, 0);
    sync_tic();
    base(3);
    chk(n_fs == f0 + 4, "R4 N=1 every tic", n_fs - f0, 4);
    sync_tic();
    chk(n_fs == f0 + 5 && !st_mis, "R5 N=1 sync aligned", int'(st_mis), 0);
  endtask

  task automatic t_zero();
    int f0, j0;
    write_cfg(0);
    chk(st_bad && !st_armed && !st_run, "R6 zero rejected", int'(st_bad), 1);
    f0 = n_fs;
    j0 = n_js;
    sync_tic();
    base(2);
    chk(n_fs == f0, "R6 no frames when disarmed", n_fs - f0, 0);
    chk(n_js == j0 + 1, "R6 sync still seen", n_js - j0, 1);
    write_cfg(2);
    chk(!st_bad && st_armed, "R6 nonzero clears badcfg", int'(st_bad), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_classify();
    t_arm_wait();
    t_period();
    t_align();
    t_ignored_in_run();
    t_overrun();
    t_rewrite();
    t_one();
    t_zero();
    chk(long_pulse == 0, "R9 pulses one cycle", long_pulse, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule